// File: doc/BRIEF.md
# Receive Ring Frame Writer

This block takes one received Ethernet frame at a time from a byte stream and stores it in a circular buffer of 256-byte pages held in local RAM. When the first byte arrives it decides whether the frame may be stored at all. The receiver must be running, the ring must be well formed, and at least a maximum-size frame of free space must remain between the current page and the boundary page. It then collects the six destination bytes and filters them. The filters are accept-all, broadcast, multicast through a 64-entry hash table (the hash index comes from outside), and an exact station-address match.

An accepted frame is written one byte per cycle after a 4-byte header slot. The write address wraps from the stop page back to the start page. Frames shorter than the minimum length are padded with zeros. The header is written last, because only then are the length and the next page known. The header holds a status byte, the next page and the stored length. A one-cycle completion pulse then carries the new current page, and the surrounding logic uses it both to update its pointer and to raise the receive interrupt. Frames that are refused or filtered out are drained from the stream. They leave the RAM, the pointer and the status untouched.

Stream rules: the upstream holds `in_valid`, `in_data` and `in_last` until a cycle in which `in_ready` is high, and the byte moves in that cycle. `in_ready` is high while the block waits for a frame, collects the destination, streams the body or drains a rejected frame. It is low while the held destination bytes are flushed to RAM, while padding is written and while the header is written. The ring, configuration and address inputs must stay stable for the duration of a frame.

Top module: `rx_ring_writer`

## Requirements
- R1: With `run` low, or with `stop_pg` not above `start_pg`, a frame is consumed without any RAM write and without a completion pulse.
- R2: The free space is measured in pages. It is `bnd_pg - cur_pg` when the current page is below the boundary page, and otherwise `(stop_pg - start_pg) - (cur_pg - bnd_pg)`. A frame is refused, with no write, when fewer pages remain than are needed for MAX_FRAME+4 bytes (6 pages by default).
- R3: When `rx_cfg` bit 4 is set, every frame is accepted.
- R4: Otherwise, a destination of all ones is accepted only when `rx_cfg` bit 2 is set.
- R5: Otherwise, a destination whose first byte has bit 0 set is accepted only when `rx_cfg` bit 3 is set and `mc_table[mc_hash]` is 1. `mc_hash` is sampled while the sixth frame byte is accepted.
- R6: Any other destination is accepted only when it equals `station_addr`, where the first frame byte is compared with bits 7:0.
- R7: A frame shorter than MIN_FRAME (60) bytes is stored padded with zero bytes to MIN_FRAME bytes.
- R8: The header occupies the first four bytes of the base page. Byte 0 is the status, 0x01, plus 0x20 when the first destination byte has bit 0 set. Byte 1 is the next page. Bytes 2 and 3 hold the stored length plus 4, low byte first.
- R9: Frame bytes are written in order from base page address + 4. The address wraps to `start_pg`*256 on reaching `stop_pg`*256, and every write falls inside the ring.
- R10: The next page is the base page plus (stored length + 8 + 255) / 256, less (`stop_pg - start_pg`) if the result is at or past `stop_pg`.
- R11: The base page is `cur_pg`, or `start_pg` when `cur_pg` is at or beyond MEM_END_PG.
- R12: One cycle after the last header write, `rx_done` pulses for exactly one cycle with `cur_next` holding the next page. After reset `rx_done` and `ram_we` are low.
- R13: `in_ready` follows the stream rules above, and a RAM write while `in_ready` is high only occurs for an accepted byte. A frame of fewer than 6 bytes is discarded.
- R14: A filtered-out frame causes no RAM write and no completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Receiver running |
| rx_cfg | input | 8 | Receive filter configuration (bits 2, 3, 4 used) |
| station_addr | input | 48 | Station address, first byte in bits 7:0 |
| mc_table | input | 64 | Multicast hash table |
| mc_hash | input | 6 | Hash index of the current destination |
| start_pg | input | PG_W | First page of the ring |
| stop_pg | input | PG_W | Page after the last page of the ring |
| bnd_pg | input | PG_W | Boundary page (oldest unread) |
| cur_pg | input | PG_W | Current page (next to write) |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Frame byte accepted when high with in_valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Last byte of the frame |
| ram_we | output | 1 | RAM byte write strobe |
| ram_addr | output | PG_W+8 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| rx_done | output | 1 | One-cycle frame-stored pulse |
| cur_next | output | PG_W | New current page, valid with rx_done |

## Verification
The bench builds the block with MEM_END_PG set to 32 and all other parameters at their defaults. This puts the memory end at 8 KB, so a model RAM covers the whole address range, and a current page past the memory end can be presented while the ring spans pages 4 to 16. The twelve-page ring is small enough that a full-size frame, a five-versus-six-page free-space edge on both sides of the boundary, and data wrapping from the stop page are all reached within a few frames.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_COLLECT, S_FLUSH, S_STREAM, S_PAD, S_HDR, S_DROP
  } rx_state_t;

  localparam int CFG_ALL   = 4;
  localparam int CFG_BCAST = 2;
  localparam int CFG_MCAST = 3;

  localparam logic [7:0] STAT_OK    = 8'h01;
  localparam logic [7:0] STAT_GROUP = 8'h20;

  localparam int DA_BYTES  = 6;
  localparam int HDR_BYTES = 4;
endpackage

// File: rtl/rxr_space.sv
module rxr_space #(
  parameter int PG_W       = 8,
  parameter int MAX_FRAME  = 1514,
  parameter int MEM_END_PG = 128
) (
  input  logic [PG_W-1:0] start_pg,
  input  logic [PG_W-1:0] stop_pg,
  input  logic [PG_W-1:0] bnd_pg,
  input  logic [PG_W-1:0] cur_pg,
  output logic            room_ok,
  output logic [PG_W-1:0] base_pg
);
  localparam int SW      = PG_W + 2;
  localparam int NEED_PG = (MAX_FRAME + 4 + 255) / 256;
  localparam logic [PG_W-1:0] END_PG = PG_W'(MEM_END_PG);

  logic signed [SW-1:0] ring_w, free_w;

  always_comb begin
    ring_w = $signed({2'b00, stop_pg}) - $signed({2'b00, start_pg});
    if (cur_pg < bnd_pg)
      free_w = $signed({2'b00, bnd_pg}) - $signed({2'b00, cur_pg});
    else
      free_w = ring_w - ($signed({2'b00, cur_pg}) - $signed({2'b00, bnd_pg}));
    room_ok = (stop_pg > start_pg) && (free_w >= $signed(SW'(NEED_PG)));
    base_pg = (cur_pg >= END_PG) ? start_pg : cur_pg;
  end
endmodule

// File: rtl/rxr_filter.sv
module rxr_filter
  import rxr_pkg::*;
(
  input  logic [7:0]  rx_cfg,
  input  logic [47:0] dest,
  input  logic [47:0] station,
  input  logic [63:0] mc_table,
  input  logic [5:0]  mc_hash,
  output logic        pass,
  output logic        group
);
  logic bcast;

  always_comb begin
    bcast = &dest;
    group = dest[0];
    if (rx_cfg[CFG_ALL])
      pass = 1'b1;
    else if (bcast)
      pass = rx_cfg[CFG_BCAST];
    else if (group)
      pass = rx_cfg[CFG_MCAST] && mc_table[mc_hash];
    else
      pass = (dest == station);
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int PG_W       = 8,
  parameter int MEM_END_PG = 128,
  parameter int MAX_FRAME  = 1514,
  parameter int MIN_FRAME  = 60,
  parameter int LEN_W      = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [7:0]      rx_cfg,
  input  logic [47:0]     station_addr,
  input  logic [63:0]     mc_table,
  input  logic [5:0]      mc_hash,
  input  logic [PG_W-1:0] start_pg,
  input  logic [PG_W-1:0] stop_pg,
  input  logic [PG_W-1:0] bnd_pg,
  input  logic [PG_W-1:0] cur_pg,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [7:0]      in_data,
  input  logic            in_last,
  output logic            ram_we,
  output logic [PG_W+7:0] ram_addr,
  output logic [7:0]      ram_wdata,
  output logic            rx_done,
  output logic [PG_W-1:0] cur_next
);
  localparam int AW = PG_W + 8;

  rx_state_t       st_q;
  logic [PG_W-1:0] base_q, nxt_q, cnext_q;
  logic [AW-1:0]   wr_q;
  logic [LEN_W-1:0] len_q;
  logic [47:0]     da_q;
  logic [2:0]      k_q;
  logic            grp_q, fin_q, done_q;

  logic            room_ok, pass_w, grp_w;
  logic [PG_W-1:0] base_w;
  logic [LEN_W-1:0] tot_w, span_w;
  logic [AW-1:0]   np_w;

  rxr_space #(.PG_W(PG_W), .MAX_FRAME(MAX_FRAME), .MEM_END_PG(MEM_END_PG)) u_space (
    .start_pg(start_pg), .stop_pg(stop_pg), .bnd_pg(bnd_pg), .cur_pg(cur_pg),
    .room_ok(room_ok), .base_pg(base_w)
  );

  rxr_filter u_filt (
    .rx_cfg(rx_cfg), .dest({in_data, da_q[39:0]}), .station(station_addr),
    .mc_table(mc_table), .mc_hash(mc_hash), .pass(pass_w), .group(grp_w)
  );

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a);
    logic [AW-1:0] n;
    n = a + AW'(1);
    if (n == {stop_pg, 8'h00}) n = {start_pg, 8'h00};
    return n;
  endfunction

  // stored length, page span and next page
  always_comb begin
    tot_w  = len_q + LEN_W'(HDR_BYTES);
    span_w = tot_w + LEN_W'(HDR_BYTES + 255);
    np_w   = AW'(base_q) + AW'(span_w >> 8);
    if (np_w >= AW'(stop_pg)) np_w = np_w - AW'(stop_pg - start_pg);
  end

  always_comb begin
    in_ready  = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = wr_q;
    ram_wdata = in_data;
    case (st_q)
      S_IDLE, S_COLLECT, S_DROP: in_ready = 1'b1;
      S_FLUSH: begin
        ram_we    = 1'b1;
        ram_wdata = da_q[{k_q, 3'b000} +: 8];
      end
      S_STREAM: begin
        in_ready = 1'b1;
        ram_we   = in_valid;
      end
      S_PAD: begin
        ram_we    = (len_q < LEN_W'(MIN_FRAME));
        ram_wdata = 8'h00;
      end
      S_HDR: begin
        ram_we   = 1'b1;
        ram_addr = {base_q, 6'b000000, k_q[1:0]};
        case (k_q[1:0])
          2'd0:    ram_wdata = STAT_OK | (grp_q ? STAT_GROUP : 8'h00);
          2'd1:    ram_wdata = 8'(nxt_q);
          2'd2:    ram_wdata = tot_w[7:0];
          default: ram_wdata = 8'(tot_w >> 8);
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      base_q  <= '0;
      nxt_q   <= '0;
      cnext_q <= '0;
      wr_q    <= '0;
      len_q   <= '0;
      da_q    <= '0;
      k_q     <= '0;
      grp_q   <= 1'b0;
      fin_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (in_valid) begin
          if (!(run && room_ok)) begin
            st_q <= in_last ? S_IDLE : S_DROP;
          end else begin
            da_q[7:0] <= in_data;
            len_q     <= LEN_W'(1);
            base_q    <= base_w;
            wr_q      <= {base_w, 8'(HDR_BYTES)};
            st_q      <= in_last ? S_IDLE : S_COLLECT;
          end
        end
        S_COLLECT: if (in_valid) begin
          da_q[{len_q[2:0], 3'b000} +: 8] <= in_data;
          len_q <= len_q + LEN_W'(1);
          if (len_q == LEN_W'(DA_BYTES - 1)) begin
            if (pass_w) begin
              grp_q <= grp_w;
              fin_q <= in_last;
              k_q   <= '0;
              st_q  <= S_FLUSH;
            end else begin
              st_q <= in_last ? S_IDLE : S_DROP;
            end
          end else if (in_last) begin
            st_q <= S_IDLE;
          end
        end
        S_FLUSH: begin
          wr_q <= step(wr_q);
          if (k_q == 3'(DA_BYTES - 1)) begin
            k_q  <= '0;
            st_q <= fin_q ? S_PAD : S_STREAM;
          end else begin
            k_q <= k_q + 3'd1;
          end
        end
        S_STREAM: if (in_valid) begin
          wr_q  <= step(wr_q);
          len_q <= len_q + LEN_W'(1);
          if (in_last) st_q <= S_PAD;
        end
        S_PAD: begin
          if (len_q < LEN_W'(MIN_FRAME)) begin
            wr_q  <= step(wr_q);
            len_q <= len_q + LEN_W'(1);
          end else begin
            nxt_q <= np_w[PG_W-1:0];
            k_q   <= '0;
            st_q  <= S_HDR;
          end
        end
        S_HDR: begin
          k_q <= k_q + 3'd1;
          if (k_q == 3'(HDR_BYTES - 1)) begin
            done_q  <= 1'b1;
            cnext_q <= nxt_q;
            st_q    <= S_IDLE;
          end
        end
        S_DROP: if (in_valid && in_last) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign rx_done  = done_q;
  assign cur_next = cnext_q;
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int PG_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PG_W-1:0] start_pg,
  input logic [PG_W-1:0] stop_pg,
  input logic            in_valid,
  input logic            in_ready,
  input logic            ram_we,
  input logic [PG_W+7:0] ram_addr,
  input logic            rx_done,
  input logic [PG_W-1:0] cur_next
);
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  // R12
  done_after_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(ram_we));

  // R9
  wr_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr[PG_W+7:8] >= start_pg && ram_addr[PG_W+7:8] < stop_pg));

  // R10
  next_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> (cur_next >= start_pg && cur_next < stop_pg));

  // R13
  accept_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && in_ready) |-> in_valid);
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.PG_W(PG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_pg(start_pg), .stop_pg(stop_pg),
  .in_valid(in_valid), .in_ready(in_ready), .ram_we(ram_we),
  .ram_addr(ram_addr), .rx_done(rx_done), .cur_next(cur_next)
);

// File: tb/sim_rx_ring_writer.sv
module sim_rx_ring_writer;
  localparam int PG_W = 8;
  localparam int MEM_END = 32;
  localparam logic [47:0] STA = 48'h55_44_33_22_11_02;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b1;
  logic [7:0] rx_cfg = '0;
  logic [63:0] mc_table = 64'h0000_0000_0000_0010;
  logic [5:0] mc_hash = '0;
  logic [PG_W-1:0] start_pg = 8'h04, stop_pg = 8'h10, bnd_pg = 8'h04, cur_pg = 8'h04;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, ram_we, rx_done;
  logic [PG_W+7:0] ram_addr;
  logic [7:0] ram_wdata;
  logic [PG_W-1:0] cur_next;

  always #10 clk = ~clk;

  rx_ring_writer #(.PG_W(PG_W), .MEM_END_PG(MEM_END)) u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .rx_cfg(rx_cfg), .station_addr(STA),
    .mc_table(mc_table), .mc_hash(mc_hash), .start_pg(start_pg), .stop_pg(stop_pg),
    .bnd_pg(bnd_pg), .cur_pg(cur_pg), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .rx_done(rx_done), .cur_next(cur_next)
  );

  int checks = 0, fails = 0;
  int wr_cnt = 0, done_cnt = 0;
  logic saw_stall = 1'b0;
  logic [7:0] mem [0:8191];
  int exp_np = 0;

  always @(negedge clk) begin
    if (ram_we) begin
      mem[ram_addr[12:0]] = ram_wdata;
      wr_cnt = wr_cnt + 1;
    end
    if (rx_done) done_cnt = done_cnt + 1;
    if (!in_ready) saw_stall = 1'b1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input int kind, input int i);
    logic [47:0] d;
    if (i >= 6) return 8'((i * 7 + 3) & 255);
    case (kind)
      0: d = STA;
      1: d = 48'h56_44_33_22_11_02;
      2: d = 48'hff_ff_ff_ff_ff_ff;
      default: d = 48'h01_00_00_5e_00_01;
    endcase
    return d[i*8 +: 8];
  endfunction

  task automatic send(input int kind, input int len);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_data  = fbyte(kind, i);
      in_last  = (i == len - 1);
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic frame(input string tag, input int cfg, input int kind, input int hash,
                       input int len, input int cur, input int bnd, input bit acc);
    int base, plen, tot, np, bad, s, e, a;
    rx_cfg = 8'(cfg); mc_hash = 6'(hash);
    cur_pg = 8'(cur); bnd_pg = 8'(bnd);
    @(posedge clk); #1;
    wr_cnt = 0; done_cnt = 0;
    send(kind, len);
    repeat (100) @(negedge clk);
    if (!acc) begin
      chk({tag, " no writes"}, wr_cnt, 0);
      chk({tag, " no done"}, done_cnt, 0);
      return;
    end
    base = (cur >= MEM_END) ? int'(start_pg) : cur;
    plen = (len < 60) ? 60 : len;
    tot  = plen + 4;
    np   = base + (tot + 4 + 255) / 256;
    if (np >= int'(stop_pg)) np -= int'(stop_pg) - int'(start_pg);
    exp_np = np;
    s = int'(start_pg) * 256; e = int'(stop_pg) * 256;
    chk({tag, " R12 done pulses"}, done_cnt, 1);
    chk({tag, " R10 next page"}, int'(cur_next), np);
    chk({tag, " R9 write count"}, wr_cnt, 4 + plen);
    chk({tag, " R8 status"}, int'(mem[base*256]), (fbyte(kind, 0) & 8'h01) ? 8'h21 : 8'h01);
    chk({tag, " R8 next byte"}, int'(mem[base*256+1]), np);
    chk({tag, " R8 len lo"}, int'(mem[base*256+2]), tot & 255);
    chk({tag, " R8 len hi"}, int'(mem[base*256+3]), tot >> 8);
    bad = 0;
    for (int i = 0; i < plen; i++) begin
      a = s + ((base * 256 + 4 + i - s) % (e - s));
      if (mem[a] != ((i < len) ? fbyte(kind, i) : 8'h00)) bad++;
    end
    chk({tag, " R9 R7 data mismatches"}, bad, 0);
  endtask

  // cfg[28:21] kind[20:19] hash[18:13] len[12:1] accept[0]
  localparam int NV = 12;
  localparam logic [28:0] VEC [NV] = '{
    {8'h00, 2'd0, 6'd0, 12'd100,  1'b1},  // R6 station match
    {8'h00, 2'd1, 6'd0, 12'd100,  1'b0},  // R6 R14 other unicast
    {8'h04, 2'd2, 6'd0, 12'd64,   1'b1},  // R4 broadcast on
    {8'h00, 2'd2, 6'd0, 12'd64,   1'b0},  // R4 broadcast off
    {8'h08, 2'd3, 6'd4, 12'd80,   1'b1},  // R5 hash hit
    {8'h08, 2'd3, 6'd5, 12'd80,   1'b0},  // R5 hash miss
    {8'h00, 2'd3, 6'd4, 12'd80,   1'b0},  // R5 multicast off
    {8'h10, 2'd1, 6'd0, 12'd70,   1'b1},  // R3 accept all
    {8'h10, 2'd3, 6'd5, 12'd61,   1'b1},  // R3 accept all group
    {8'h00, 2'd0, 6'd0, 12'd20,   1'b1},  // R7 short frame
    {8'h00, 2'd0, 6'd0, 12'd600,  1'b1},  // R10 multi page
    {8'h0c, 2'd0, 6'd0, 12'd1514, 1'b1}   // R2 full-size frame
  };

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cur;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset rx_done", int'(rx_done), 0);
    chk("R12 reset ram_we", int'(ram_we), 0);
    chk("R13 reset in_ready", int'(in_ready), 1);

    cur = 4;
    for (int v = 0; v < NV; v++) begin
      frame($sformatf("vec%0d", v), int'(VEC[v][28:21]), int'(VEC[v][20:19]),
            int'(VEC[v][18:13]), int'(VEC[v][12:1]), cur, cur, VEC[v][0]);
      if (VEC[v][0]) cur = exp_np;
    end

    // R1 stopped receiver and malformed ring
    run = 1'b0;
    frame("R1 stopped", 0, 0, 0, 100, 4, 4, 1'b0);
    run = 1'b1;
    stop_pg = 8'h04;
    frame("R1 stop not above start", 0, 0, 0, 100, 4, 4, 1'b0);
    stop_pg = 8'h10;

    // R2 free-space edge on both sides of the boundary
    frame("R2 five pages above", 0, 0, 0, 100, 8'h0b, 8'h04, 1'b0);
    frame("R2 six pages above", 0, 0, 0, 100, 8'h0a, 8'h04, 1'b1);
    frame("R2 five pages below", 0, 0, 0, 100, 8'h04, 8'h09, 1'b0);
    frame("R2 six pages below", 0, 0, 0, 100, 8'h04, 8'h0a, 1'b1);

    // R9 data wraps from the stop page to the start page
    frame("R9 wrap", 0, 0, 0, 300, 8'h0f, 8'h0f, 1'b1);
    chk("R9 first wrapped byte", int'(mem[16'h0400]), int'(fbyte(0, 252)));
    chk("R10 wrapped next page", int'(cur_next), 5);

    // R11 current page beyond memory end
    frame("R11 base from start", 0, 0, 0, 100, 8'h20, 8'h20, 1'b1);
    chk("R11 next page", int'(cur_next), 5);

    // R13 stall seen on a normal frame, and a frame too short to filter
    saw_stall = 1'b0;
    frame("R13 stall frame", 0, 0, 0, 100, 4, 4, 1'b1);
    chk("R13 in_ready dropped", int'(saw_stall), 1);
    frame("R13 four-byte frame", 8'h10, 0, 0, 4, 4, 4, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule